// File: doc/BRIEF.md
# QRSS Loopback Self-Test Controller

This block is the built-in self-test engine of a T1 line interface. Software sets a self-test control bit. The block then sends a quasi-random signal source (QRSS) bit stream out on the transmit data path, one bit for each pulse of the transmit bit enable. Outside the block, the stream passes through the transmit chain and comes back through the receive chain. The receive side of the block samples the returning bits on its own enable. A self-synchronising pattern checker finds the pattern's phase by itself, so the loop may add any pipeline delay.

The test ends on pattern lock, not on an error count. When the checker locks, three sticky status bits rise together and the active-low interrupt is pulled low. The completion pin goes high when the test starts and stays high until the test passes. If the timeout expires before lock, the pin stays high and no success bit is ever set, so software can tell a failed test from a passed one. Writing the control bit back to zero aborts the test. The whole function exists only in host mode.

Top module: `qrss_bist`

## Requirements
- R1: A write to the control bit has no effect while `host_mode` is 0. Dropping `host_mode` during a test aborts it, exactly like writing the control bit to 0 (R7).
- R2: `tx_data` carries the pattern of a LFSR_W-stage shift register, polynomial x^20 + x^17 + 1 by default. The register is loaded with all ones at start. Each bit is the XOR of stage LFSR_W and stage LFSR_TAP (1-based), and that bit is also shifted in at the low end. The register advances once per `tx_bit_en` pulse. `tx_data` is 0 while no test is active.
- R3: When the checker locks during a test, `st_tx_qrss`, `st_pat_qrss` and `st_pat_bist` all become 1 on the same clock edge.
- R4: `int_n` is 0 exactly while at least one status bit is 1.
- R5: `qpd` goes to 1 on the clock edge after the control bit is written from 0 to 1. It stays 1 during the test and drops to 0 on the edge where the status bits are set.
- R6: A pulse on `stat_rd` clears all three status bits, which releases `int_n`. It does not restart the test.
- R7: Writing the control bit to 0 returns `qpd` to 0 and clears the status bits. No status bit is set afterwards, even if a pattern later arrives, until a new test is started.
- R8: If no lock occurs within 2^TIMEOUT_W transmit bit times, the test fails. `qpd` then stays 1 and the status bits stay 0, even if a correct pattern arrives later.
- R9: Lock requires LOCK_RUN consecutive received bits (taken on `rx_bit_en`) that match the prediction. It works for any loop delay. A stream with an error every 30 bits never locks. Sparse errors only delay lock.
- R10: `tx_data` never carries more than MAX_ZEROS consecutive zero bits. When the shift register would produce one more zero, a 1 is sent instead.
- R11: Writing 1 to the control bit while it is already 1 neither restarts the test nor changes `qpd` or the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 when the device is under register control |
| ctl_wr | input | 1 | Write strobe for the self-test control bit |
| ctl_wdata | input | 1 | Value written to the control bit |
| stat_rd | input | 1 | Host read strobe; clears the sticky status bits |
| tx_bit_en | input | 1 | One pulse per transmit bit time |
| tx_data | output | 1 | Transmit pattern bit, valid while `tx_bit_en` is high |
| rx_bit_en | input | 1 | One pulse per receive bit time |
| rx_data | input | 1 | Looped-back receive bit, sampled with `rx_bit_en` |
| st_tx_qrss | output | 1 | Sticky transmit-status pattern bit |
| st_pat_qrss | output | 1 | Sticky pattern-status pattern bit |
| st_pat_bist | output | 1 | Sticky pattern-status self-test bit |
| int_n | output | 1 | Active-low interrupt |
| qpd | output | 1 | Completion pin: high while running or failed, low on pass or idle |

## Verification
The bench builds the block with MAX_ZEROS = 7 and TIMEOUT_W = 12. It keeps the 20-stage register, LOCK_RUN = 32, WIN_LEN = 64 and ERR_LIMIT = 4. With the lower zero limit, forced ones occur many times in each test, so both the transmit substitution and the checker's prediction of forced ones are tested. With the short timeout, a failed test is reached in a few thousand cycles. The bench can then show that a correct pattern arriving after the failure sets nothing. Loop delays from 0 to 60 bits, random enable gaps, and random, periodic or dense bit errors cover the checker's search behaviour.

// File: rtl/qrss_pkg.sv
package qrss_pkg;
    typedef enum logic [1:0] {
        BIST_IDLE = 2'd0,
        BIST_RUN  = 2'd1,
        BIST_PASS = 2'd2,
        BIST_FAIL = 2'd3
    } bist_state_e;
endpackage

// File: rtl/qrss_gen.sv
module qrss_gen #(
    parameter int LFSR_W    = 20,
    parameter int LFSR_TAP  = 17,
    parameter int MAX_ZEROS = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_en,
    output logic tx_bit
);
    localparam int ZW = $clog2(MAX_ZEROS + 1);
    localparam logic [ZW-1:0] ZMAX = ZW'(MAX_ZEROS);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [ZW-1:0]     zc;
    } gen_t;

    gen_t g_d, g_q;
    logic raw, outb;

    always_comb begin
        raw  = g_q.lfsr[LFSR_W-1] ^ g_q.lfsr[LFSR_TAP-1];
        outb = raw | (g_q.zc == ZMAX);
        g_d  = g_q;
        if (!run) begin
            g_d.lfsr = '1;
            g_d.zc   = '0;
        end else if (bit_en) begin
            g_d.lfsr = {g_q.lfsr[LFSR_W-2:0], raw};
            g_d.zc   = outb ? '0 : g_q.zc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.lfsr <= '1;
            g_q.zc   <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign tx_bit = run & outb;

    p_zero_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.zc <= ZMAX);
    p_idle_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (g_q.lfsr == '1 && g_q.zc == '0));
endmodule

// File: rtl/qrss_det.sv
module qrss_det #(
    parameter int LFSR_W    = 20,
    parameter int LFSR_TAP  = 17,
    parameter int MAX_ZEROS = 14,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_en,
    input  logic rx_bit,
    output logic locked
);
    localparam int ZW = $clog2(MAX_ZEROS + 1);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam int WW = $clog2(WIN_LEN);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam logic [ZW-1:0] ZMAX     = ZW'(MAX_ZEROS);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
    localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_LIMIT);

    typedef struct packed {
        logic [LFSR_W-1:0] sh;
        logic [ZW-1:0]     zc;
        logic [RW-1:0]     run_cnt;
        logic [WW-1:0]     win;
        logic [EW-1:0]     err;
        logic              lock;
    } det_t;

    det_t d_d, d_q;
    logic pred_raw, forced, pred_out, match;
    logic [EW-1:0] err_sum;

    always_comb begin
        pred_raw = d_q.sh[LFSR_W-1] ^ d_q.sh[LFSR_TAP-1];
        forced   = (d_q.zc == ZMAX) && !pred_raw;
        pred_out = pred_raw | forced;
        match    = (rx_bit == pred_out);
        err_sum  = d_q.err + EW'(!match);
        d_d      = d_q;
        if (!run) begin
            d_d = '0;
        end else if (bit_en) begin
            if (!d_q.lock) begin
                // search: build the register from the line, undoing forced ones
                d_d.sh = {d_q.sh[LFSR_W-2:0], forced ? pred_raw : rx_bit};
                d_d.zc = (rx_bit || forced) ? '0 : d_q.zc + 1'b1;
                if (!match) begin
                    d_d.run_cnt = '0;
                end else if (d_q.run_cnt == RUN_LAST) begin
                    d_d.lock    = 1'b1;
                    d_d.run_cnt = '0;
                    d_d.win     = '0;
                    d_d.err     = '0;
                end else begin
                    d_d.run_cnt = d_q.run_cnt + 1'b1;
                end
            end else begin
                // locked: flywheel on the local prediction
                d_d.sh = {d_q.sh[LFSR_W-2:0], pred_raw};
                d_d.zc = pred_out ? '0 : d_q.zc + 1'b1;
                if (err_sum >= ERR_TOP) begin
                    d_d = '0;
                end else if (d_q.win == WIN_LAST) begin
                    d_d.win = '0;
                    d_d.err = '0;
                end else begin
                    d_d.win = d_q.win + 1'b1;
                    d_d.err = err_sum;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign locked = d_q.lock;

    p_lock_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_q.lock) |-> ($past(d_q.run_cnt) == RUN_LAST && $past(bit_en)));
    p_err_below_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.err < ERR_TOP);
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !d_q.lock);
endmodule

// File: rtl/qrss_ctrl.sv
module qrss_ctrl
    import qrss_pkg::*;
#(
    parameter int TIMEOUT_W = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic ctl_wr,
    input  logic ctl_wdata,
    input  logic stat_rd,
    input  logic tx_bit_en,
    input  logic det_locked,
    output logic run,
    output logic st_tx_qrss,
    output logic st_pat_qrss,
    output logic st_pat_bist,
    output logic int_n,
    output logic qpd
);
    typedef struct packed {
        bist_state_e          st;
        logic                 sbist;
        logic                 s_tx;
        logic                 s_pq;
        logic                 s_pb;
        logic [TIMEOUT_W-1:0] tmo;
    } ctl_t;

    ctl_t c_d, c_q;
    logic start, stop, hit;

    always_comb begin
        c_d = c_q;
        if (!host_mode)  c_d.sbist = 1'b0;
        else if (ctl_wr) c_d.sbist = ctl_wdata;
        start = !c_q.sbist && c_d.sbist;
        stop  = c_q.sbist && !c_d.sbist;
        hit   = (c_q.st == BIST_RUN) && det_locked;

        case (c_q.st)
            BIST_IDLE: if (start) begin
                c_d.st  = BIST_RUN;
                c_d.tmo = '0;
            end
            BIST_RUN: begin
                if (det_locked) begin
                    c_d.st = BIST_PASS;
                end else if (tx_bit_en) begin
                    if (c_q.tmo == '1) c_d.st = BIST_FAIL;
                    else               c_d.tmo = c_q.tmo + 1'b1;
                end
            end
            default: ;
        endcase

        if (stop) begin
            c_d.st   = BIST_IDLE;
            c_d.s_tx = 1'b0;
            c_d.s_pq = 1'b0;
            c_d.s_pb = 1'b0;
        end else if (hit) begin
            c_d.s_tx = 1'b1;
            c_d.s_pq = 1'b1;
            c_d.s_pb = 1'b1;
        end else if (stat_rd) begin
            c_d.s_tx = 1'b0;
            c_d.s_pq = 1'b0;
            c_d.s_pb = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= BIST_IDLE;
            c_q.sbist <= 1'b0;
            c_q.s_tx  <= 1'b0;
            c_q.s_pq  <= 1'b0;
            c_q.s_pb  <= 1'b0;
            c_q.tmo   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run         = (c_q.st != BIST_IDLE);
    assign st_tx_qrss  = c_q.s_tx;
    assign st_pat_qrss = c_q.s_pq;
    assign st_pat_bist = c_q.s_pb;
    assign int_n       = !(c_q.s_tx | c_q.s_pq | c_q.s_pb);
    assign qpd         = (c_q.st == BIST_RUN) || (c_q.st == BIST_FAIL);

    p_no_host_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |=> !qpd);
    p_start_qpd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && ctl_wr && ctl_wdata && !c_q.sbist) |=> qpd);
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && ctl_wr && !ctl_wdata) |=> (!qpd && int_n));
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == BIST_FAIL) |-> int_n);
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !det_locked) |=> int_n);
    p_pass_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qpd) && c_q.sbist |-> !int_n);
endmodule

// File: rtl/qrss_bist.sv
module qrss_bist #(
    parameter int LFSR_W    = 20,
    parameter int LFSR_TAP  = 17,
    parameter int MAX_ZEROS = 14,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 4,
    parameter int TIMEOUT_W = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic ctl_wr,
    input  logic ctl_wdata,
    input  logic stat_rd,
    input  logic tx_bit_en,
    output logic tx_data,
    input  logic rx_bit_en,
    input  logic rx_data,
    output logic st_tx_qrss,
    output logic st_pat_qrss,
    output logic st_pat_bist,
    output logic int_n,
    output logic qpd
);
    logic run, det_locked;

    qrss_ctrl #(.TIMEOUT_W(TIMEOUT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
        .tx_bit_en(tx_bit_en), .det_locked(det_locked), .run(run),
        .st_tx_qrss(st_tx_qrss), .st_pat_qrss(st_pat_qrss),
        .st_pat_bist(st_pat_bist), .int_n(int_n), .qpd(qpd)
    );

    qrss_gen #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP), .MAX_ZEROS(MAX_ZEROS)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_en(tx_bit_en), .tx_bit(tx_data)
    );

    qrss_det #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP), .MAX_ZEROS(MAX_ZEROS),
               .LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_det (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_en(rx_bit_en),
        .rx_bit(rx_data), .locked(det_locked)
    );

    p_status_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_pat_bist) |-> (st_tx_qrss && st_pat_qrss && !qpd));
    p_idle_tx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tx_data);
endmodule

// File: tb/qrss_bist_test.sv
`timescale 1ns/1ps
module qrss_bist_test;
    localparam int TW = 20, TT = 17, MZ = 7, TO_W = 12;

    logic clk = 0, rst_n = 0;
    logic host_mode = 0, ctl_wr = 0, ctl_wdata = 0, stat_rd = 0;
    logic tx_bit_en = 0, rx_bit_en = 0, rx_data = 0;
    logic tx_data, st_tx_qrss, st_pat_qrss, st_pat_bist, int_n, qpd;

    int total = 0, bad = 0;
    bit en_on = 0, chk_on = 0;
    int delay = 0, err_mode = 0, err_rate = 500, err_period = 30, per_cnt = 0;
    logic [TW-1:0] m_s;
    int m_z = 0, mm_cnt = 0, max_run = 0, cur_run = 0;
    logic line [0:63];

    always #2.5 clk = ~clk;

    qrss_bist #(.MAX_ZEROS(MZ), .TIMEOUT_W(TO_W)) uut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .stat_rd(stat_rd), .tx_bit_en(tx_bit_en),
        .tx_data(tx_data), .rx_bit_en(rx_bit_en), .rx_data(rx_data),
        .st_tx_qrss(st_tx_qrss), .st_pat_qrss(st_pat_qrss), .st_pat_bist(st_pat_bist),
        .int_n(int_n), .qpd(qpd)
    );

    function automatic logic model_step(inout logic [TW-1:0] s, inout int z);
        logic raw, o;
        raw = s[TW-1] ^ s[TT-1];
        o   = raw | (z == MZ);
        s   = {s[TW-2:0], raw};
        z   = o ? 0 : z + 1;
        return o;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // transmit enable and stream model, driven away from the active edge
    always @(negedge clk) begin
        tx_bit_en = en_on && ($urandom % 4 != 0);
        if (tx_bit_en && chk_on) begin
            logic e;
            e = model_step(m_s, m_z);
            if (tx_data != e) mm_cnt++;
            if (tx_data == 1'b0) begin
                cur_run++;
                if (cur_run > max_run) max_run = cur_run;
            end else cur_run = 0;
        end
    end

    // loopback wire: variable delay, optional bit errors
    always @(posedge clk) begin
        logic inj, b;
        if (tx_bit_en) begin
            b = (delay == 0) ? tx_data : line[delay-1];
            inj = 1'b0;
            if (err_mode == 1) inj = ($urandom % err_rate) == 0;
            else if (err_mode == 2) inj = $urandom % 2;
            else if (err_mode == 3) begin
                per_cnt = per_cnt + 1;
                if (per_cnt >= err_period) begin inj = 1'b1; per_cnt = 0; end
            end
            for (int i = 63; i > 0; i--) line[i] <= line[i-1];
            line[0]   <= tx_data;
            rx_data   <= b ^ inj;
        end
        rx_bit_en <= tx_bit_en;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic v);
        ctl_wr = 1; ctl_wdata = v;
        @(posedge clk);
        if (v && host_mode) begin
            m_s = '1; m_z = 0; cur_run = 0;
        end
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic start_test();
        mm_cnt = 0; max_run = 0;
        write_ctl(1'b1);
        chk_on = 1;
    endtask

    task automatic stop_test();
        chk_on = 0;
        write_ctl(1'b0);
    endtask

    task automatic wait_lock(input int limit, output bit got);
        got = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!int_n) begin got = 1; break; end
        end
    endtask

    task automatic status_is(input string req, input int exp3);
        check(req, {st_tx_qrss, st_pat_qrss, st_pat_bist}, exp3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit got;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) line[i] = 0;
        cyc(4);
        rst_n = 1;
        cyc(2);
        // reset state
        check("R5 reset qpd", qpd, 0);
        check("R4 reset int_n", int_n, 1);
        status_is("R3 reset status", 0);
        check("R2 reset tx_data", tx_data, 0);
        en_on = 1;

        // R1: write ignored outside host mode
        write_ctl(1'b1);
        cyc(5);
        check("R1 write ignored without host", qpd, 0);
        check("R2 tx idle without host", tx_data, 0);

        // directed lock, delay 5
        host_mode = 1;
        delay = 5; err_mode = 0;
        start_test();
        check("R5 qpd high at start", qpd, 1);
        status_is("R5 no status at start", 0);
        wait_lock(3000, got);
        check("R3 lock reached", got, 1);
        status_is("R3 all three status bits", 7);
        check("R4 int_n low", int_n, 0);
        check("R5 qpd low on pass", qpd, 0);
        check("R2 stream matches model", mm_cnt, 0);
        check("R10 zero run bounded", (max_run <= MZ) ? 1 : 0, 1);
        check("R10 forced ones seen", (max_run == MZ) ? 1 : 0, 1);

        // R11: repeated write of 1
        write_ctl(1'b1);
        cyc(3);
        check("R11 qpd unchanged", qpd, 0);
        status_is("R11 status unchanged", 7);

        // R6: host read clears
        stat_rd = 1; cyc(1); stat_rd = 0;
        status_is("R6 read clears status", 0);
        check("R6 int_n released", int_n, 1);
        check("R6 qpd stays low", qpd, 0);
        cyc(50);
        status_is("R6 no re-set after read", 0);
        stop_test();
        check("R7 qpd low after stop", qpd, 0);

        // sparse random errors, long delay
        delay = 37; err_mode = 1; err_rate = 500;
        start_test();
        wait_lock(3000, got);
        check("R9 lock with sparse errors", got, 1);
        status_is("R9 status after sparse errors", 7);
        stop_test();
        status_is("R7 stop clears status", 0);
        check("R4 int_n after stop", int_n, 1);

        // R7: abort before lock
        delay = 3; err_mode = 0;
        start_test();
        cyc(5);
        stop_test();
        check("R7 qpd low after abort", qpd, 0);
        cyc(500);
        status_is("R7 nothing set after abort", 0);
        check("R7 int_n idle after abort", int_n, 1);

        // R1: host mode dropped mid-test
        start_test();
        cyc(5);
        host_mode = 0;
        cyc(1);
        check("R1 host drop aborts", qpd, 0);
        cyc(300);
        status_is("R1 no status after host drop", 0);
        chk_on = 0;
        host_mode = 1;

        // R9: error every 30 bits never locks
        delay = 11; err_mode = 3; err_period = 30; per_cnt = 0;
        start_test();
        wait_lock(3000, got);
        check("R9 no lock with periodic errors", got, 0);
        check("R9 qpd still high", qpd, 1);
        stop_test();
        err_period = 150; per_cnt = 0;
        start_test();
        wait_lock(3000, got);
        check("R9 lock with rare periodic errors", got, 1);
        stop_test();

        // R8: timeout then late pattern sets nothing
        delay = 9; err_mode = 2;
        start_test();
        cyc(8000);
        check("R8 qpd high after timeout", qpd, 1);
        status_is("R8 no status after timeout", 0);
        err_mode = 0;
        cyc(2000);
        check("R8 qpd still high", qpd, 1);
        status_is("R8 late pattern ignored", 0);
        check("R8 int_n idle", int_n, 1);
        stop_test();
        check("R7 stop after fail", qpd, 0);

        // random loop delays
        for (int t = 0; t < 8; t++) begin
            delay = $urandom % 61;
            err_mode = ($urandom % 2 == 0) ? 0 : 1;
            err_rate = 400 + $urandom % 600;
            start_test();
            wait_lock(3000, got);
            check($sformatf("R9 random delay %0d locks", delay), got, 1);
            status_is("R3 random status", 7);
            check("R5 random qpd pass", qpd, 0);
            check("R2 random stream", mm_cnt, 0);
            check("R10 random zero run", (max_run <= MZ) ? 1 : 0, 1);
            stop_test();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule